// File: doc/BRIEF.md
# DDR SDRAM Burst Column Sequencer

This block turns one decoded column command (read or write) into the column address stream and data-beat timing of a DDR SDRAM burst. The command arrives with its bank, its column field and its auto-precharge bit. The block waits out the read latency or the write latency, then presents one column address per data beat. Addresses wrap inside the aligned block that the burst length defines, in sequential or interleaved order. When the burst ends, the block raises a one-step done flag. If auto-precharge was requested, it also raises a precharge request for the burst's bank.

The block counts in half-clock steps. `step_en` is the 2x-rate enable: each rising clock edge with `step_en` high is one data-beat slot. A CAS latency of 2.5 clocks is therefore five steps. Commands are sampled on stepping edges only.

A running burst can be cut short in three ways: by a burst-terminate command, by a precharge that hits its bank, or by a fresh read that restarts the stream. Commands that the current burst does not allow are flagged and otherwise ignored.

Top module: `ddr_burst_seq`

## Requirements
- R1: While `rst` is high, and on the first step after it falls, the outputs `beat_valid_o`, `burst_active_o`, `burst_done_o`, `ap_req_o` and `cmd_illegal_o` are all 0.
- R2: `cmd_op` codes are: 0 no-op, 1 read, 2 write, 3 terminate, 4 precharge one bank, 5 precharge all. A read accepted at step s gives its first beat at step s+4 when `mode_cl`=0 (2 clocks) and at step s+5 when `mode_cl`=1 (2.5 clocks). The following beats come on consecutive steps.
- R3: A write accepted at step s gives its first beat at step s+2. `beat_rd_o` is 1 on read beats and 0 on write beats.
- R4: `mode_bl` codes are: 01 for 2 beats, 10 for 4 beats, 11 for 8 beats, and 00 is treated as 2 beats. A burst that runs to its end gives exactly that many beats. `burst_active_o` is high from the accepting step up to the last beat. On the step after the last beat, `burst_done_o` pulses for one step and `burst_active_o` falls.
- R5: The column is {A11, A9..A0} of `cmd_addr`. With `mode_bt`=0 (sequential), beat i carries low bits (start + i) mod BL. The column bits above the wrap block stay unchanged.
- R6: With `mode_bt`=1 (interleaved), beat i carries low bits start XOR i, inside the same aligned block.
- R7: If A10 (`cmd_addr[10]`) was 1, `ap_req_o` pulses at the same step as `burst_done_o`, with `ap_bank_o` equal to the burst's bank. With A10 at 0, `ap_req_o` stays 0.
- R8: A read accepted during a read burst without auto-precharge ends the old stream at that step. A new burst then starts at the new column, with the latency of R2 and the mode held for the old burst. No done pulse is given for the old burst.
- R9: A terminate during a read burst without auto-precharge ends the burst at that step: `beat_valid_o`=0, `burst_active_o`=0 and `burst_done_o`=1.
- R10: During a write burst or a read burst with auto-precharge, a terminate pulses `cmd_illegal_o` and the burst continues unchanged. A read or write command that R8 does not cover, given while a burst is active, also pulses `cmd_illegal_o` and is ignored. A terminate while idle has no effect and sets no flag.
- R11: During a read burst, precharge-all, or a one-bank precharge whose bank equals the burst's bank, ends the burst as in R9 and gives no `ap_req_o`. A one-bank precharge to another bank has no effect.
- R12: The mode inputs are sampled only while no burst is active. Changes made during a burst do not alter its length, order or latency.
- R13: On a clock edge with `step_en` low, no output changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_en | input | 1 | Half-clock beat step enable (2x rate) |
| cmd_valid | input | 1 | Command present this step |
| cmd_op | input | 3 | Command code |
| cmd_bank | input | BANK_W | Bank of the command |
| cmd_addr | input | 12 | Address A11..A0; A10 is the auto-precharge bit |
| mode_bl | input | 2 | Burst length code |
| mode_bt | input | 1 | Wrap order: 0 sequential, 1 interleaved |
| mode_cl | input | 1 | Read latency: 0 is 2 clocks, 1 is 2.5 clocks |
| col_o | output | 11 | Column address of the current beat |
| beat_valid_o | output | 1 | A beat is presented this step |
| beat_rd_o | output | 1 | Current beat belongs to a read |
| burst_active_o | output | 1 | A burst is in progress |
| burst_done_o | output | 1 | One-step pulse at burst end |
| ap_req_o | output | 1 | Auto-precharge request pulse |
| ap_bank_o | output | BANK_W | Bank to precharge |
| cmd_illegal_o | output | 1 | Command refused in the current burst state |

## Verification
The bench builds the block with its defaults: read latencies of 4 and 5 steps, a write latency of 2 steps, and a 2-bit bank. These are short enough that every burst length, both wrap orders and both read latencies are covered in a few hundred steps. Interruptions are placed on chosen beats of a running burst: before the first beat, mid-stream, and together with mode changes. A stretch with `step_en` held low checks that the outputs freeze and that the beat schedule then resumes where it stopped.

// File: rtl/ddr_seq_pkg.sv
package ddr_seq_pkg;

  typedef enum logic [2:0] {
    OP_NOP   = 3'd0,
    OP_READ  = 3'd1,
    OP_WRITE = 3'd2,
    OP_TERM  = 3'd3,
    OP_PRE   = 3'd4,
    OP_PREA  = 3'd5
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_BEAT
  } seq_st_e;

  typedef struct packed {
    logic [1:0] bl;
    logic       bt;
    logic       cl;
  } mode_t;

endpackage

// File: rtl/ddr_mode_hold.sv
module ddr_mode_hold
  import ddr_seq_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  step_en,
  input  logic  freeze,
  input  mode_t mode_in,
  output mode_t mode_eff,
  output mode_t mode_q
);

  // While frozen the held copy is used; otherwise the live inputs pass through.
  assign mode_eff = freeze ? mode_q : mode_in;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '{bl: 2'b01, bt: 1'b0, cl: 1'b0};
    end else if (step_en) begin
      mode_q <= mode_eff;
    end
  end

endmodule

// File: rtl/ddr_col_gen.sv
module ddr_col_gen #(
  parameter int COL_W = 11,
  parameter int IDX_W = 3
) (
  input  logic [COL_W-1:0] base,
  input  logic [IDX_W-1:0] idx,
  input  logic [1:0]       bl_code,
  input  logic             ilv,
  output logic [COL_W-1:0] col
);

  logic [IDX_W-1:0] wrap_mask;
  logic [IDX_W-1:0] seq_low;
  logic [IDX_W-1:0] ilv_low;
  logic [IDX_W-1:0] pick_low;

  always_comb begin
    case (bl_code)
      2'b11:   wrap_mask = IDX_W'(7);
      2'b10:   wrap_mask = IDX_W'(3);
      default: wrap_mask = IDX_W'(1);
    endcase
  end

  assign seq_low  = base[IDX_W-1:0] + idx;
  assign ilv_low  = base[IDX_W-1:0] ^ idx;
  assign pick_low = ilv ? ilv_low : seq_low;

  // Bits inside the wrap block take the ordered value, the rest keep the base.
  for (genvar b = 0; b < IDX_W; b++) begin : g_low
    assign col[b] = wrap_mask[b] ? pick_low[b] : base[b];
  end

  assign col[COL_W-1:IDX_W] = base[COL_W-1:IDX_W];

endmodule

// File: rtl/ddr_burst_ctl.sv
module ddr_burst_ctl
  import ddr_seq_pkg::*;
#(
  parameter int BANK_W      = 2,
  parameter int COL_W       = 11,
  parameter int IDX_W       = 3,
  parameter int CL_LO_STEPS = 4,
  parameter int CL_HI_STEPS = 5,
  parameter int WL_STEPS    = 2,
  parameter int LAT_W       = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step_en,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [BANK_W-1:0] cmd_bank,
  input  logic [COL_W-1:0]  cmd_col,
  input  logic              cmd_ap,
  input  logic [1:0]        bl_code,
  input  logic              cl_half,
  output logic [COL_W-1:0]  nxt_base,
  output logic [IDX_W-1:0]  nxt_idx,
  output logic              nxt_beat,
  output logic              beat_valid_o,
  output logic              beat_rd_o,
  output logic              burst_active_o,
  output logic              burst_done_o,
  output logic              ap_req_o,
  output logic [BANK_W-1:0] ap_bank_o,
  output logic              cmd_illegal_o
);

  seq_st_e           st_q, st_n;
  logic [LAT_W-1:0]  cnt_q, cnt_n;
  logic [IDX_W-1:0]  idx_q, idx_n;
  logic [COL_W-1:0]  base_q, base_n;
  logic [BANK_W-1:0] bank_q, bank_n;
  logic              ap_q, ap_n;
  logic              rd_q, rd_n;
  logic              done_n, apreq_n, ill_n;
  logic [IDX_W-1:0]  last_idx;
  logic [LAT_W-1:0]  load_cnt;
  logic              active, is_col, is_rd, is_term, hits_pre, may_restart;

  always_comb begin
    case (bl_code)
      2'b11:   last_idx = IDX_W'(7);
      2'b10:   last_idx = IDX_W'(3);
      default: last_idx = IDX_W'(1);
    endcase
  end

  assign is_rd       = (cmd_op == OP_READ);
  assign active      = (st_q != ST_IDLE);
  assign is_col      = cmd_valid && (is_rd || cmd_op == OP_WRITE);
  assign is_term     = cmd_valid && (cmd_op == OP_TERM);
  assign hits_pre    = cmd_valid && ((cmd_op == OP_PREA) ||
                       ((cmd_op == OP_PRE) && (cmd_bank == bank_q)));
  assign may_restart = active && rd_q && !ap_q && is_rd;

  // Counter value loaded so that the first beat lands exactly latency steps later.
  always_comb begin
    if (!is_rd)       load_cnt = LAT_W'(WL_STEPS - 1);
    else if (cl_half) load_cnt = LAT_W'(CL_HI_STEPS - 1);
    else              load_cnt = LAT_W'(CL_LO_STEPS - 1);
  end

  always_comb begin
    st_n     = st_q;
    cnt_n    = cnt_q;
    idx_n    = idx_q;
    base_n   = base_q;
    bank_n   = bank_q;
    ap_n     = ap_q;
    rd_n     = rd_q;
    nxt_beat = 1'b0;
    done_n   = 1'b0;
    apreq_n  = 1'b0;
    ill_n    = 1'b0;

    // Normal progression of the running burst.
    case (st_q)
      ST_WAIT: begin
        if (cnt_q == '0) begin
          st_n     = ST_BEAT;
          idx_n    = '0;
          nxt_beat = 1'b1;
        end else begin
          cnt_n = cnt_q - LAT_W'(1);
        end
      end
      ST_BEAT: begin
        if (idx_q == last_idx) begin
          st_n    = ST_IDLE;
          done_n  = 1'b1;
          apreq_n = ap_q;
        end else begin
          idx_n    = idx_q + IDX_W'(1);
          nxt_beat = 1'b1;
        end
      end
      default: ;
    endcase

    // Commands override the progression.
    if (is_col && (!active || may_restart)) begin
      st_n     = ST_WAIT;
      cnt_n    = load_cnt;
      idx_n    = '0;
      base_n   = cmd_col;
      bank_n   = cmd_bank;
      ap_n     = cmd_ap;
      rd_n     = is_rd;
      nxt_beat = 1'b0;
      done_n   = 1'b0;
      apreq_n  = 1'b0;
    end else if (is_col) begin
      ill_n = 1'b1;
    end else if (is_term && active) begin
      if (rd_q && !ap_q) begin
        st_n     = ST_IDLE;
        nxt_beat = 1'b0;
        done_n   = 1'b1;
        apreq_n  = 1'b0;
      end else begin
        ill_n = 1'b1;
      end
    end else if (hits_pre && active) begin
      if (rd_q) begin
        st_n     = ST_IDLE;
        nxt_beat = 1'b0;
        done_n   = 1'b1;
        apreq_n  = 1'b0;
      end else begin
        ill_n = 1'b1;
      end
    end
  end

  assign nxt_base = base_n;
  assign nxt_idx  = idx_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q           <= ST_IDLE;
      cnt_q          <= '0;
      idx_q          <= '0;
      base_q         <= '0;
      bank_q         <= '0;
      ap_q           <= 1'b0;
      rd_q           <= 1'b0;
      beat_valid_o   <= 1'b0;
      beat_rd_o      <= 1'b0;
      burst_active_o <= 1'b0;
      burst_done_o   <= 1'b0;
      ap_req_o       <= 1'b0;
      ap_bank_o      <= '0;
      cmd_illegal_o  <= 1'b0;
    end else if (step_en) begin
      st_q           <= st_n;
      cnt_q          <= cnt_n;
      idx_q          <= idx_n;
      base_q         <= base_n;
      bank_q         <= bank_n;
      ap_q           <= ap_n;
      rd_q           <= rd_n;
      beat_valid_o   <= nxt_beat;
      beat_rd_o      <= rd_n;
      burst_active_o <= (st_n != ST_IDLE);
      burst_done_o   <= done_n;
      ap_req_o       <= apreq_n;
      if (apreq_n) ap_bank_o <= bank_q;
      cmd_illegal_o  <= ill_n;
    end
  end

endmodule

// File: rtl/ddr_burst_seq.sv
module ddr_burst_seq
  import ddr_seq_pkg::*;
#(
  parameter int BANK_W      = 2,
  parameter int CL_LO_STEPS = 4,
  parameter int CL_HI_STEPS = 5,
  parameter int WL_STEPS    = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step_en,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [BANK_W-1:0] cmd_bank,
  input  logic [11:0]       cmd_addr,
  input  logic [1:0]        mode_bl,
  input  logic              mode_bt,
  input  logic              mode_cl,
  output logic [10:0]       col_o,
  output logic              beat_valid_o,
  output logic              beat_rd_o,
  output logic              burst_active_o,
  output logic              burst_done_o,
  output logic              ap_req_o,
  output logic [BANK_W-1:0] ap_bank_o,
  output logic              cmd_illegal_o
);

  localparam int COL_W   = 11;
  localparam int IDX_W   = 3;
  localparam int LAT_MAX = (CL_HI_STEPS > WL_STEPS) ? CL_HI_STEPS : WL_STEPS;
  localparam int LAT_W   = $clog2(LAT_MAX + 1);

  mode_t             mode_in, mode_eff, mode_held;
  logic [COL_W-1:0]  cmd_col;
  logic [COL_W-1:0]  nxt_base, col_c;
  logic [IDX_W-1:0]  nxt_idx;
  logic              nxt_beat;

  assign mode_in = '{bl: mode_bl, bt: mode_bt, cl: mode_cl};
  assign cmd_col = {cmd_addr[11], cmd_addr[9:0]};

  ddr_mode_hold u_mode (
    .clk      (clk),
    .rst      (rst),
    .step_en  (step_en),
    .freeze   (burst_active_o),
    .mode_in  (mode_in),
    .mode_eff (mode_eff),
    .mode_q   (mode_held)
  );

  ddr_burst_ctl #(
    .BANK_W      (BANK_W),
    .COL_W       (COL_W),
    .IDX_W       (IDX_W),
    .CL_LO_STEPS (CL_LO_STEPS),
    .CL_HI_STEPS (CL_HI_STEPS),
    .WL_STEPS    (WL_STEPS),
    .LAT_W       (LAT_W)
  ) u_ctl (
    .clk            (clk),
    .rst            (rst),
    .step_en        (step_en),
    .cmd_valid      (cmd_valid),
    .cmd_op         (cmd_op),
    .cmd_bank       (cmd_bank),
    .cmd_col        (cmd_col),
    .cmd_ap         (cmd_addr[10]),
    .bl_code        (mode_eff.bl),
    .cl_half        (mode_eff.cl),
    .nxt_base       (nxt_base),
    .nxt_idx        (nxt_idx),
    .nxt_beat       (nxt_beat),
    .beat_valid_o   (beat_valid_o),
    .beat_rd_o      (beat_rd_o),
    .burst_active_o (burst_active_o),
    .burst_done_o   (burst_done_o),
    .ap_req_o       (ap_req_o),
    .ap_bank_o      (ap_bank_o),
    .cmd_illegal_o  (cmd_illegal_o)
  );

  ddr_col_gen #(
    .COL_W (COL_W),
    .IDX_W (IDX_W)
  ) u_col (
    .base    (nxt_base),
    .idx     (nxt_idx),
    .bl_code (mode_eff.bl),
    .ilv     (mode_eff.bt),
    .col     (col_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      col_o <= '0;
    end else if (step_en && nxt_beat) begin
      col_o <= col_c;
    end
  end

endmodule

// File: rtl/ddr_burst_seq_chk.sv
module ddr_burst_seq_chk #(
  parameter int COL_W = 11
) (
  input logic             clk,
  input logic             rst,
  input logic             step_en,
  input logic             beat_valid_o,
  input logic             burst_active_o,
  input logic             burst_done_o,
  input logic             ap_req_o,
  input logic [COL_W-1:0] col_o,
  input logic [3:0]       mode_held
);

  AST_BEAT_INSIDE_BURST: assert property (@(posedge clk) disable iff (rst)
    beat_valid_o |-> burst_active_o); // R4

  AST_DONE_DROPS_ACTIVE: assert property (@(posedge clk) disable iff (rst)
    burst_done_o |-> !burst_active_o); // R4

  AST_DONE_SINGLE_STEP: assert property (@(posedge clk) disable iff (rst)
    (burst_done_o && step_en) |=> !burst_done_o); // R4

  AST_AP_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    ap_req_o |-> burst_done_o); // R7

  AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (rst)
    burst_active_o |=> $stable(mode_held)); // R12

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !step_en |=> ($stable(col_o) && $stable(beat_valid_o) &&
                  $stable(burst_active_o) && $stable(burst_done_o) &&
                  $stable(ap_req_o))); // R13

endmodule

bind ddr_burst_seq ddr_burst_seq_chk u_chk (
  .clk            (clk),
  .rst            (rst),
  .step_en        (step_en),
  .beat_valid_o   (beat_valid_o),
  .burst_active_o (burst_active_o),
  .burst_done_o   (burst_done_o),
  .ap_req_o       (ap_req_o),
  .col_o          (col_o),
  .mode_held      (mode_held)
);

// File: tb/sim_ddr_burst_seq.sv
module sim_ddr_burst_seq;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        step_en = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_op = 3'd0;
  logic [1:0]  cmd_bank = 2'd0;
  logic [11:0] cmd_addr = 12'd0;
  logic [1:0]  mode_bl = 2'b01;
  logic        mode_bt = 1'b0;
  logic        mode_cl = 1'b0;
  logic [10:0] col_o;
  logic        beat_valid_o, beat_rd_o, burst_active_o, burst_done_o;
  logic        ap_req_o, cmd_illegal_o;
  logic [1:0]  ap_bank_o;

  ddr_burst_seq u0 (
    .clk(clk), .rst(rst), .step_en(step_en), .cmd_valid(cmd_valid),
    .cmd_op(cmd_op), .cmd_bank(cmd_bank), .cmd_addr(cmd_addr),
    .mode_bl(mode_bl), .mode_bt(mode_bt), .mode_cl(mode_cl),
    .col_o(col_o), .beat_valid_o(beat_valid_o), .beat_rd_o(beat_rd_o),
    .burst_active_o(burst_active_o), .burst_done_o(burst_done_o),
    .ap_req_o(ap_req_o), .ap_bank_o(ap_bank_o), .cmd_illegal_o(cmd_illegal_o)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  typedef struct {
    int          step;
    logic [10:0] col;
    bit          rd;
    string       tag;
  } beat_t;

  beat_t q[$];
  int    nchk = 0;
  int    nerr = 0;
  int    stepc = 0;
  bit    stepped = 1'b0;
  bit    fin = 1'b0;

  always @(posedge clk) begin
    stepped <= step_en;
    if (step_en) stepc <= stepc + 1;
  end

  task automatic check(string tag, int act, int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d at step %0d", tag, act, exp, stepc);
    end
  endtask

  function automatic logic [10:0] ecol(logic [10:0] c, int i, int n, bit ilv);
    int ci = int'(c);
    int lo = ci % n;
    int l2 = ilv ? (lo ^ i) : ((lo + i) % n);
    return 11'(ci - lo + l2);
  endfunction

  task automatic push_burst(int s0, int lat, logic [10:0] c, int n, bit ilv, bit rd, string tag);
    for (int k = 0; k < n; k++) begin
      beat_t b;
      b.step = s0 + lat + k;
      b.col  = ecol(c, k, n, ilv);
      b.rd   = rd;
      b.tag  = tag;
      q.push_back(b);
    end
  endtask

  task automatic purge(int s);
    beat_t keep[$];
    foreach (q[i]) if (q[i].step < s) keep.push_back(q[i]);
    q = keep;
  endtask

  task automatic issue(logic [2:0] op, logic [1:0] bk, logic [11:0] a, output int s);
    s = stepc + 1;
    cmd_valid = 1'b1;
    cmd_op    = op;
    cmd_bank  = bk;
    cmd_addr  = a;
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_op    = 3'd0;
  endtask

  task automatic wait_step(int s);
    while (stepc < s) @(negedge clk);
  endtask

  task automatic set_mode(logic [1:0] bl, logic bt, logic cl);
    mode_bl = bl;
    mode_bt = bt;
    mode_cl = cl;
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
  endtask

  // Scoreboard monitor: compares every stepped beat with the queue head.
  always @(negedge clk) begin
    if (!rst && stepped) begin
      if (beat_valid_o) begin
        if (q.size() == 0) begin
          check("R4 unexpected beat", 1, 0);
        end else if (q[0].step != stepc) begin
          check("R2 beat step", stepc, q[0].step);
        end else begin
          check(q[0].tag, int'(col_o), int'(q[0].col));
          check("R3 beat_rd", int'(beat_rd_o), int'(q[0].rd));
          void'(q.pop_front());
        end
      end else if (q.size() != 0 && q[0].step == stepc) begin
        check("R2 missing beat", 0, 1);
        void'(q.pop_front());
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!fin) begin
      nerr++;
      nchk++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    int s0, s1, sx;
    repeat (4) @(negedge clk);
    // R1: reset state
    check("R1 active in reset", int'(burst_active_o), 0);
    check("R1 beat in reset", int'(beat_valid_o), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 done after reset", int'(burst_done_o), 0);
    check("R1 ap_req after reset", int'(ap_req_o), 0);
    check("R1 illegal after reset", int'(cmd_illegal_o), 0);
    check("R1 active after reset", int'(burst_active_o), 0);

    // R2 R4 R5: read, 4 beats sequential, latency 2
    set_mode(2'b10, 1'b0, 1'b0);
    issue(3'd1, 2'd1, 12'h005, s0);
    push_burst(s0, 4, 11'h005, 4, 1'b0, 1'b1, "R5 seq col");
    check("R4 active after command", int'(burst_active_o), 1);
    wait_step(s0 + 8);
    check("R4 done pulse", int'(burst_done_o), 1);
    check("R4 active falls", int'(burst_active_o), 0);
    check("R7 no ap_req without A10", int'(ap_req_o), 0);

    // R6 R2 R5: 8 beats interleaved, latency 2.5, A11 maps to column bit 10
    set_mode(2'b11, 1'b1, 1'b1);
    issue(3'd1, 2'd0, 12'h8F3, s0);
    push_burst(s0, 5, 11'h4F3, 8, 1'b1, 1'b1, "R6 interleave col");
    wait_step(s0 + 13);
    check("R4 done after 8 beats", int'(burst_done_o), 1);

    // R3 R7: write, 2 beats, auto-precharge to bank 2
    set_mode(2'b01, 1'b0, 1'b0);
    issue(3'd2, 2'd2, 12'h501, s0);
    push_burst(s0, 2, 11'h101, 2, 1'b0, 1'b0, "R3 write col");
    wait_step(s0 + 4);
    check("R7 done with ap", int'(burst_done_o), 1);
    check("R7 ap_req pulse", int'(ap_req_o), 1);
    check("R7 ap_bank", int'(ap_bank_o), 2);
    @(negedge clk);
    check("R7 ap_req one step", int'(ap_req_o), 0);

    // R12: mode change during burst is ignored
    set_mode(2'b01, 1'b0, 1'b0);
    issue(3'd1, 2'd0, 12'h010, s0);
    set_mode(2'b11, 1'b1, 1'b1);
    push_burst(s0, 4, 11'h010, 2, 1'b0, 1'b1, "R12 frozen col");
    wait_step(s0 + 6);
    check("R12 length held at 2", int'(burst_done_o), 1);

    // R8: read restarts a read burst without auto-precharge
    set_mode(2'b11, 1'b0, 1'b0);
    issue(3'd1, 2'd0, 12'h020, s0);
    push_burst(s0, 4, 11'h020, 8, 1'b0, 1'b1, "R8 first col");
    set_mode(2'b01, 1'b1, 1'b1);
    wait_step(s0 + 6);
    purge(stepc + 1);
    issue(3'd1, 2'd0, 12'h033, s1);
    push_burst(s1, 4, 11'h033, 8, 1'b0, 1'b1, "R8 restart col");
    check("R8 no done on restart", int'(burst_done_o), 0);
    check("R8 active on restart", int'(burst_active_o), 1);
    wait_step(s1 + 12);
    check("R8 done after restart", int'(burst_done_o), 1);

    // R9: terminate a read without auto-precharge
    set_mode(2'b11, 1'b0, 1'b0);
    issue(3'd1, 2'd3, 12'h040, s0);
    push_burst(s0, 4, 11'h040, 8, 1'b0, 1'b1, "R9 col");
    wait_step(s0 + 5);
    purge(stepc + 1);
    issue(3'd3, 2'd0, 12'h000, sx);
    check("R9 done on term", int'(burst_done_o), 1);
    check("R9 active off", int'(burst_active_o), 0);
    check("R9 beat off", int'(beat_valid_o), 0);

    // R10: terminate and read refused during write
    set_mode(2'b10, 1'b0, 1'b0);
    issue(3'd2, 2'd1, 12'h050, s0);
    push_burst(s0, 2, 11'h050, 4, 1'b0, 1'b0, "R10 write col");
    wait_step(s0 + 2);
    issue(3'd3, 2'd0, 12'h000, sx);
    check("R10 illegal term", int'(cmd_illegal_o), 1);
    check("R10 write continues", int'(burst_active_o), 1);
    issue(3'd1, 2'd1, 12'h000, sx);
    check("R10 illegal read", int'(cmd_illegal_o), 1);
    wait_step(s0 + 6);
    check("R10 write completes", int'(burst_done_o), 1);

    // R11: precharge other bank ignored, matching bank ends read with AP
    set_mode(2'b10, 1'b0, 1'b0);
    issue(3'd1, 2'd2, 12'h460, s0);
    push_burst(s0, 4, 11'h060, 4, 1'b0, 1'b1, "R11 col");
    issue(3'd4, 2'd1, 12'h000, sx);
    check("R11 other bank no flag", int'(cmd_illegal_o), 0);
    check("R11 other bank keeps burst", int'(burst_active_o), 1);
    wait_step(s0 + 5);
    purge(stepc + 1);
    issue(3'd4, 2'd2, 12'h000, sx);
    check("R11 pre ends burst", int'(burst_done_o), 1);
    check("R11 pre no ap_req", int'(ap_req_o), 0);
    check("R11 active off", int'(burst_active_o), 0);

    // R11: precharge-all during read
    set_mode(2'b11, 1'b0, 1'b0);
    issue(3'd1, 2'd0, 12'h080, s0);
    push_burst(s0, 4, 11'h080, 8, 1'b0, 1'b1, "R11 prea col");
    wait_step(s0 + 4);
    purge(stepc + 1);
    issue(3'd5, 2'd3, 12'h000, sx);
    check("R11 prea ends burst", int'(burst_done_o), 1);

    // R13: steps held off freeze outputs
    set_mode(2'b10, 1'b0, 1'b0);
    issue(3'd2, 2'd0, 12'h070, s0);
    push_burst(s0, 2, 11'h070, 4, 1'b0, 1'b0, "R13 col");
    wait_step(s0 + 2);
    step_en = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check("R13 beat held", int'(beat_valid_o), 1);
      check("R13 col held", int'(col_o), 'h070);
    end
    step_en = 1'b1;
    wait_step(s0 + 6);
    check("R13 done after stall", int'(burst_done_o), 1);

    // R10: terminate while idle
    issue(3'd3, 2'd0, 12'h000, sx);
    check("R10 idle term no flag", int'(cmd_illegal_o), 0);
    check("R10 idle term stays idle", int'(burst_active_o), 0);

    repeat (4) @(negedge clk);
    check("R2 all beats seen", q.size(), 0);
    fin = 1'b1;
    summary();
    $finish;
  end

endmodule